// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block is a first-in first-out buffer between two unrelated clock domains. Words enter on the write clock and leave on the read clock. Both pointers cross between the domains as Gray code through two-flop synchronizers. Because of this, each domain sees the other side's pointer a few cycles late. Its full and empty decisions are therefore pessimistic but never unsafe. The storage holds `1 << ADDR_W` words of `DATA_W` bits. The defaults are 18 bits and a small array; a 32768-word array uses `ADDR_W = 15`.

A synchronous, active-low master reset picks the read timing. The level on `modeIn` while reset is low selects it, and the choice then holds until the next reset.

- In standard timing, the output register changes only on an explicit read. The read-side primary flag means "empty" and the write-side primary flag means "full".
- In fall-through timing, the oldest word moves into the output register by itself. Each later word advances only on a read. The same two flags then mean "output holds a valid word" and "storage can take a write".

The half-full, almost-full and almost-empty flags work in both modes. The almost-full and almost-empty thresholds are set by parameters. An output-enable input qualifies the data bus.

Top module: `dualmode_fifo`

## Requirements
- R1: On each rising `wrClk` edge with `wrEn` high and storage not full, the word on `din` is stored. A write while storage is full is dropped: it changes neither the pointer nor the stored words.
- R2: In standard mode, `dout` changes only on a rising `rdClk` edge with `rdEn` high while storage is not empty. It then shows the oldest unread word, in write order. A read while empty is dropped, and `dout` keeps its value.
- R3: The timing mode is captured from `modeIn` (0 = standard, 1 = fall-through) while `mrstN` is low. Changing `modeIn` after reset has no effect.
- R4: In fall-through mode, the first word written into an empty FIFO appears on `dout` with no read enable. The word stays there until a read edge, which replaces it with the next word in write order.
- R5: The primary flags are active high. In standard mode, `rdFlag` = empty and `wrFlag` = full. In fall-through mode, `rdFlag` = output word valid and `wrFlag` = storage not full. In that mode the storage holds DEPTH words behind the output register.
- R6: `halfFull` is 1 when the write-side count of words in storage is greater than DEPTH/2.
- R7: `almostFull` is 1 when the write-side count of words in storage is at least DEPTH - AF_OFF.
- R8: `almostEmpty` is 1 when the read-side count of words in storage is at most AE_OFF.
- R9: `doutDrive` follows `oe`. When `oe` is 0, `dout` reads as zero. When `oe` is 1, `dout` shows the output register.
- R10: Each Gray-coded pointer changes in at most one bit per clock of its domain, and this holds across pointer wrap.
- R11: After reset, storage is empty and `dout` is zero. In standard mode the flags are `rdFlag`=1, `wrFlag`=0, `halfFull`=0, `almostEmpty`=1 and `almostFull`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| wrEn | input | 1 | Write request |
| din | input | DATA_W | Write data |
| rdClk | input | 1 | Read-domain clock |
| rdEn | input | 1 | Read request |
| oe | input | 1 | Output enable for `dout` |
| mrstN | input | 1 | Master reset, active low, synchronous in each domain |
| modeIn | input | 1 | Timing select sampled during reset (1 = fall-through) |
| dout | output | DATA_W | Read data, zero when `oe` is low |
| doutDrive | output | 1 | Bus drive qualifier, follows `oe` |
| rdFlag | output | 1 | Empty (standard) or output valid (fall-through) |
| wrFlag | output | 1 | Full (standard) or input ready (fall-through) |
| halfFull | output | 1 | Write-side count above DEPTH/2 |
| almostEmpty | output | 1 | Read-side count at or below AE_OFF |
| almostFull | output | 1 | Write-side count at or above DEPTH - AF_OFF |

## Verification
The bench first fills an eight-word configuration one word at a time and then drains it. At each count it compares all five flags with thresholds computed arithmetically. A wrong threshold comparison therefore shows up at the exact count where the flag should switch.

It also writes into a full FIFO and reads from an empty one. A design that does not drop these would corrupt the drained sequence, or would move `dout` after the last word. A second pass makes the pointers wrap, which exposes a full/empty compare on the wrong Gray bits.

In fall-through mode, the bench checks three things. The first word must appear with no read. It must stay put while more words arrive. Nine words must fit in total. A design that reused standard timing, or changed mode when `modeIn` moved after reset, would fail these checks.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifoMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic memWrite;   // write-domain: store din at wrAddr
    logic outLoad;    // read-domain: copy mem[rdAddr] into output register
    logic outClear;   // read-domain: clear output register
  } fifoStrobes_t;

endpackage

// File: rtl/fifo_sync.sv
`timescale 1ns/1ps
module fifo_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fifo_ctrl.sv
`timescale 1ns/1ps
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int AE_OFF = 2,
  parameter int AF_OFF = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              modeIn,
  input  logic              wrEn,
  input  logic              rdEn,
  output fifoStrobes_t      strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdFlag,
  output logic              wrFlag,
  output logic              halfFull,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);
  localparam logic [PW-1:0] AF_LVL   = PW'(DEPTH - AF_OFF);
  localparam logic [PW-1:0] AE_LVL   = PW'(AE_OFF);
  localparam logic [PW-1:0] DEPTH_LVL = PW'(DEPTH);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  fifoMode_e     modeW;
  logic [PW-1:0] wBin, wGray, rGraySync, rBinSync, wLevel;
  logic          fullW, wrOk;

  always_ff @(posedge wrClk) begin
    if (!mrstN) modeW <= fifoMode_e'(modeIn);
  end

  fifo_sync #(.W(PW)) uRdPtrSync (
    .clk (wrClk),
    .rstN(mrstN),
    .d   (rGray),
    .q   (rGraySync)
  );

  always_comb begin
    rBinSync = fromGray(rGraySync);
    fullW    = (wGray == {~rGraySync[PW-1:PW-2], rGraySync[PW-3:0]});
    wrOk     = wrEn && !fullW;
    wLevel   = wBin - rBinSync;
  end

  always_ff @(posedge wrClk) begin
    if (!mrstN) begin
      wBin  <= '0;
      wGray <= '0;
    end else if (wrOk) begin
      wBin  <= wBin + 1'b1;
      wGray <= toGray(wBin + 1'b1);
    end
  end

  assign wrAddr      = wBin[ADDR_W-1:0];
  assign halfFull    = (wLevel > HALF_LVL);
  assign almostFull  = (wLevel >= AF_LVL);
  assign wrFlag      = (modeW == MODE_FWFT) ? !fullW : fullW;

  // ---------------- read domain ----------------
  fifoMode_e     modeR;
  logic [PW-1:0] rBin, rGray, wGraySync, wBinSync, rLevel;
  logic          emptyR, take, outValid;

  always_ff @(posedge rdClk) begin
    if (!mrstN) modeR <= fifoMode_e'(modeIn);
  end

  fifo_sync #(.W(PW)) uWrPtrSync (
    .clk (rdClk),
    .rstN(mrstN),
    .d   (wGray),
    .q   (wGraySync)
  );

  always_comb begin
    wBinSync = fromGray(wGraySync);
    emptyR   = (rGray == wGraySync);
    rLevel   = wBinSync - rBin;
    if (modeR == MODE_FWFT) take = !emptyR && (!outValid || rdEn);
    else                    take = rdEn && !emptyR;
  end

  always_ff @(posedge rdClk) begin
    if (!mrstN) begin
      rBin     <= '0;
      rGray    <= '0;
      outValid <= 1'b0;
    end else begin
      if (take) begin
        rBin  <= rBin + 1'b1;
        rGray <= toGray(rBin + 1'b1);
      end
      if (modeR == MODE_FWFT) begin
        if (take)      outValid <= 1'b1;
        else if (rdEn) outValid <= 1'b0;
      end
    end
  end

  assign rdAddr      = rBin[ADDR_W-1:0];
  assign almostEmpty = (rLevel <= AE_LVL);
  assign rdFlag      = (modeR == MODE_FWFT) ? outValid : emptyR;

  always_comb begin
    strb.memWrite = wrOk;
    strb.outLoad  = take;
    strb.outClear = !mrstN;
  end

  // ---------------- assertions ----------------
  p_full_write_dropped_r1: assert property (@(posedge wrClk) disable iff (!mrstN)
    (wrEn && fullW) |=> $stable(wBin));

  p_empty_read_dropped_r2: assert property (@(posedge rdClk) disable iff (!mrstN)
    (modeR == MODE_STD && rdEn && emptyR) |=> $stable(rBin));

  p_mode_fixed_r3: assert property (@(posedge rdClk) disable iff (!mrstN)
    $past(mrstN) |-> $stable(modeR));

  p_ready_holds_r4: assert property (@(posedge rdClk) disable iff (!mrstN)
    (modeR == MODE_FWFT && outValid && !rdEn) |=> (outValid && $stable(rBin)));

  p_level_bound_r6: assert property (@(posedge wrClk) disable iff (!mrstN)
    wLevel <= DEPTH_LVL);

  p_wgray_step_r10: assert property (@(posedge wrClk) disable iff (!mrstN)
    $countones(wGray ^ $past(wGray)) <= 1);

  p_rgray_step_r10: assert property (@(posedge rdClk) disable iff (!mrstN)
    $countones(rGray ^ $past(rGray)) <= 1);

endmodule

// File: rtl/fifo_datapath.sv
`timescale 1ns/1ps
module fifo_datapath
  import fifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 3
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  fifoStrobes_t      strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] din,
  input  logic              oe,
  output logic [DATA_W-1:0] dout,
  output logic              doutDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge wrClk) begin
    if (strb.memWrite) mem[wrAddr] <= din;
  end

  always_ff @(posedge rdClk) begin
    if (strb.outClear)     outReg <= '0;
    else if (strb.outLoad) outReg <= mem[rdAddr];
  end

  assign dout      = oe ? outReg : '0;
  assign doutDrive = oe;

  p_undriven_zero_r9: assert property (@(posedge rdClk) !oe |-> (dout == '0));
endmodule

// File: rtl/dualmode_fifo.sv
`timescale 1ns/1ps
module dualmode_fifo
  import fifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10,
  parameter int AE_OFF = 8,
  parameter int AF_OFF = 8
) (
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] din,
  input  logic              rdClk,
  input  logic              rdEn,
  input  logic              oe,
  input  logic              mrstN,
  input  logic              modeIn,
  output logic [DATA_W-1:0] dout,
  output logic              doutDrive,
  output logic              rdFlag,
  output logic              wrFlag,
  output logic              halfFull,
  output logic              almostEmpty,
  output logic              almostFull
);
  fifoStrobes_t      strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  fifo_ctrl #(.ADDR_W(ADDR_W), .AE_OFF(AE_OFF), .AF_OFF(AF_OFF)) uCtrl (
    .wrClk      (wrClk),
    .rdClk      (rdClk),
    .mrstN      (mrstN),
    .modeIn     (modeIn),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .strb       (strb),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .rdFlag     (rdFlag),
    .wrFlag     (wrFlag),
    .halfFull   (halfFull),
    .almostEmpty(almostEmpty),
    .almostFull (almostFull)
  );

  fifo_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uData (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .din      (din),
    .oe       (oe),
    .dout     (dout),
    .doutDrive(doutDrive)
  );
endmodule

// File: tb/tb_dualmode_fifo.sv
`timescale 1ns/1ps
module tb_dualmode_fifo;
  localparam int DW = 18;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int AE = 2;
  localparam int AF = 2;

  logic wrClk = 0, rdClk = 0;
  logic wrEn = 0, rdEn = 0, oe = 1, mrstN = 0, modeIn = 0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic doutDrive, rdFlag, wrFlag, halfFull, almostEmpty, almostFull;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 wrClk = ~wrClk;   // 250 MHz
  always #3 rdClk = ~rdClk;

  dualmode_fifo #(.DATA_W(DW), .ADDR_W(AW), .AE_OFF(AE), .AF_OFF(AF)) dut (
    .wrClk(wrClk), .wrEn(wrEn), .din(din), .rdClk(rdClk), .rdEn(rdEn),
    .oe(oe), .mrstN(mrstN), .modeIn(modeIn), .dout(dout), .doutDrive(doutDrive),
    .rdFlag(rdFlag), .wrFlag(wrFlag), .halfFull(halfFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rdClk);
    repeat (6) @(negedge wrClk);
  endtask

  task automatic doReset(input logic m);
    mrstN  = 0;
    modeIn = m;
    repeat (4) @(negedge rdClk);
    repeat (4) @(negedge wrClk);
    mrstN = 1;
    settle();
  endtask

  task automatic wr(input int v);
    @(negedge wrClk);
    din  = DW'(v);
    wrEn = 1;
    @(negedge wrClk);
    wrEn = 0;
  endtask

  task automatic rd();
    @(negedge rdClk);
    rdEn = 1;
    @(negedge rdClk);
    rdEn = 0;
  endtask

  task automatic flagsAt(input string tag, input int lvl);
    check({tag, " R6 halfFull"}, int'(halfFull), int'(lvl > DEPTH / 2));
    check({tag, " R7 almostFull"}, int'(almostFull), int'(lvl >= DEPTH - AF));
    check({tag, " R8 almostEmpty"}, int'(almostEmpty), int'(lvl <= AE));
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // ---- standard mode ----
    doReset(1'b0);
    check("R11 rdFlag empty", int'(rdFlag), 1);
    check("R11 wrFlag", int'(wrFlag), 0);
    check("R11 dout", int'(dout), 0);
    flagsAt("R11", 0);

    for (int k = 1; k <= DEPTH; k++) begin
      wr(100 + k);
      settle();
      check("R5 std empty flag", int'(rdFlag), 0);
      check("R5 std full flag", int'(wrFlag), int'(k == DEPTH));
      flagsAt("fill", k);
      if (k == 1) check("R2 no fall-through", int'(dout), 0);
    end

    wr(999);   // dropped: full
    settle();
    check("R1 still full", int'(wrFlag), 1);
    flagsAt("R1 after drop", DEPTH);

    for (int k = 1; k <= DEPTH; k++) begin
      rd();
      settle();
      check("R2 read order", int'(dout), 100 + k);
      check("R5 std empty flag", int'(rdFlag), int'(k == DEPTH));
      check("R5 std full flag", int'(wrFlag), 0);
      flagsAt("drain", DEPTH - k);
    end

    rd();      // dropped: empty
    settle();
    check("R2 empty read holds dout", int'(dout), 100 + DEPTH);
    check("R2 still empty", int'(rdFlag), 1);

    // wrap pointers past the array end
    for (int k = 1; k <= 5; k++) begin
      wr(200 + k);
      settle();
    end
    for (int k = 1; k <= 5; k++) begin
      rd();
      settle();
      check("R10 wrap order", int'(dout), 200 + k);
    end
    check("R10 wrap empty", int'(rdFlag), 1);

    oe = 0;
    #1;
    check("R9 dout zero", int'(dout), 0);
    check("R9 drive low", int'(doutDrive), 0);
    oe = 1;
    #1;
    check("R9 dout back", int'(dout), 205);
    check("R9 drive high", int'(doutDrive), 1);

    // ---- fall-through mode ----
    doReset(1'b1);
    modeIn = 0;   // must be ignored after reset
    settle();
    check("R5 fwft not ready", int'(rdFlag), 0);
    check("R5 fwft input ready", int'(wrFlag), 1);
    check("R11 fwft dout", int'(dout), 0);

    wr(301);
    settle();
    check("R4 first word ready", int'(rdFlag), 1);
    check("R4 first word shown", int'(dout), 301);
    check("R3 mode kept", int'(wrFlag), 1);

    for (int k = 2; k <= DEPTH + 1; k++) begin
      wr(300 + k);
      settle();
      check("R4 head held", int'(dout), 301);
      check("R5 fwft input ready", int'(wrFlag), int'(k < DEPTH + 1));
      flagsAt("fwft fill", k - 1);
    end

    wr(999);   // dropped: storage full
    settle();
    check("R1 fwft drop", int'(wrFlag), 0);

    for (int k = 1; k <= DEPTH + 1; k++) begin
      check("R4 fwft order", int'(dout), 300 + k);
      check("R5 fwft ready", int'(rdFlag), 1);
      rd();
      settle();
    end
    check("R5 fwft drained", int'(rdFlag), 0);
    check("R5 fwft input ready", int'(wrFlag), 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule